// File: doc/BRIEF.md
# Reprogrammable Multi-Hot Automaton Pattern Matcher

This block runs a nondeterministic finite automaton directly in logic. Every automaton state owns one flip-flop, and any number of them may be set at once, so all candidate paths through the automaton are followed in parallel on each input byte. Bytes arrive on a valid/data pair. A byte is first translated to one of 64 character classes by a writable lookup table. The next state vector is then formed from the current vector and that class through a fixed all-to-all interconnect whose product terms are gated by writable coefficients.

Software installs an automaton by writing class masks for each (destination, source) pair of states, the byte-to-class table, a start mask and an accepting mask, all through one write port, while a configuration-mode input keeps the state vector parked at the start mask. The start mask is merged into every step, so a pattern may begin at any byte position (unanchored search). A registered match flag reports that an accepting state became active on the previous byte.

Top module: `nfa_matcher`

## Requirements
- R1: While reset is asserted and on leaving it, the state vector reads 0 and the match flag reads 0; all coefficients, the start mask and the accepting mask are 0 and every byte maps to class 0.
- R2: With the configuration-mode input high, at each clock edge the state vector loads the start mask and match clears, whatever the stream inputs carry.
- R3: A high synchronous clear (with configuration mode low) loads the start mask into the state vector and clears match at the next edge.
- R4: On an edge where the stream valid input is low (and neither clear nor configuration mode is high), the state vector holds and match reads 0.
- R5: On a valid byte with class c, next state bit i is 1 when start-mask bit i is 1, or when for some source j state bit j is 1 and bit c of the coefficient word at address i*16+j (write select 0) is 1.
- R6: One active source may enable several destinations on the same byte, and several active sources are followed at once; all resulting bits are set together.
- R7: Write select 1 stores data bits [5:0] as the class of the byte value given by the address; the new class is used for subsequent bytes.
- R8: Write select 3 stores the accepting mask and select 2 the start mask (data bits [15:0]); match is 1 in the cycle after a valid byte exactly when the state vector then produced has a bit in common with the accepting mask.
- R9: The start mask is merged into the state vector on every valid byte, so a pattern is found after any number of leading unrelated bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode | input | 1 | Configuration mode; parks the state vector at the start mask |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Write target: 0 coefficients, 1 class table, 2 start mask, 3 accepting mask |
| cfgAddr | input | 8 | Pair address {destination, source} or byte value |
| cfgData | input | 64 | Write data (class mask, class number, or state mask) |
| clear | input | 1 | Synchronous clear of the state vector to the start mask |
| inValid | input | 1 | Stream byte valid |
| inByte | input | 8 | Stream byte |
| match | output | 1 | An accepting state was reached by the previous byte |
| stateVec | output | 16 | Current set of active states |

## Verification
The hardest situation to reach is a cycle where several sources and several destinations are live together, since that needs a coefficient set in which one class fans out from one state while an older path is still alive. The stimulus installs two overlapping patterns sharing a first character plus a wildcard edge, then feeds byte sequences with leading noise so the start state, a partial path and an accepting state coexist; a class table rewrite, idle cycles, a mid-stream clear and bytes sent during configuration mode cover the remaining control paths.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
  localparam int DEF_STATES  = 16;
  localparam int DEF_CLASSES = 64;
  localparam int BYTE_W      = 8;

  localparam logic [1:0] SEL_COEF   = 2'd0;
  localparam logic [1:0] SEL_CLASS  = 2'd1;
  localparam logic [1:0] SEL_START  = 2'd2;
  localparam logic [1:0] SEL_ACCEPT = 2'd3;

  typedef struct packed {
    logic coefWe;
    logic classWe;
    logic startWe;
    logic acceptWe;
    logic loadStart;
    logic advance;
  } nfaCtrl_t;
endpackage

// File: rtl/nfa_ctrl.sv
module nfa_ctrl
  import nfa_pkg::*;
(
  input  logic       cfgMode,
  input  logic       cfgWe,
  input  logic [1:0] cfgSel,
  input  logic       clear,
  input  logic       inValid,
  output nfaCtrl_t   ctrl
);
  always_comb begin
    ctrl.coefWe    = cfgWe && (cfgSel == SEL_COEF);
    ctrl.classWe   = cfgWe && (cfgSel == SEL_CLASS);
    ctrl.startWe   = cfgWe && (cfgSel == SEL_START);
    ctrl.acceptWe  = cfgWe && (cfgSel == SEL_ACCEPT);
    ctrl.loadStart = cfgMode || clear;
    ctrl.advance   = inValid && !(cfgMode || clear);
  end
endmodule

// File: rtl/nfa_datapath.sv
module nfa_datapath
  import nfa_pkg::*;
#(
  parameter int NUM_STATES  = DEF_STATES,
  parameter int NUM_CLASSES = DEF_CLASSES,
  localparam int SRC_W     = $clog2(NUM_STATES),
  localparam int CLASS_W   = $clog2(NUM_CLASSES),
  localparam int PAIRS     = NUM_STATES * NUM_STATES,
  localparam int MAP_DEPTH = 1 << BYTE_W,
  localparam int ADDR_W    = (2 * SRC_W > BYTE_W) ? 2 * SRC_W : BYTE_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  nfaCtrl_t               ctrl,
  input  logic [ADDR_W-1:0]      cfgAddr,
  input  logic [NUM_CLASSES-1:0] cfgData,
  input  logic [BYTE_W-1:0]      inByte,
  output logic [NUM_STATES-1:0]  stateVec,
  output logic                   match
);
  logic [NUM_CLASSES-1:0] coefMem [PAIRS];
  logic [CLASS_W-1:0]     classMap [MAP_DEPTH];
  logic [NUM_STATES-1:0]  startMask, acceptMask;
  logic [CLASS_W-1:0]     curClass;
  logic [NUM_STATES-1:0]  stepVec, nextVec;

  // Coefficient and class storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < PAIRS; k++) coefMem[k] <= '0;
      for (int k = 0; k < MAP_DEPTH; k++) classMap[k] <= '0;
      startMask  <= '0;
      acceptMask <= '0;
    end else begin
      if (ctrl.coefWe)   coefMem[cfgAddr[2*SRC_W-1:0]] <= cfgData;
      if (ctrl.classWe)  classMap[cfgAddr[BYTE_W-1:0]] <= cfgData[CLASS_W-1:0];
      if (ctrl.startWe)  startMask  <= cfgData[NUM_STATES-1:0];
      if (ctrl.acceptWe) acceptMask <= cfgData[NUM_STATES-1:0];
    end
  end

  assign curClass = classMap[inByte];

  // Fixed interconnect: every destination sees every source and the class
  for (genvar i = 0; i < NUM_STATES; i++) begin : g_dest
    always_comb begin
      stepVec[i] = 1'b0;
      for (int j = 0; j < NUM_STATES; j++)
        stepVec[i] = stepVec[i] | (stateVec[j] & coefMem[i*NUM_STATES+j][curClass]);
    end
  end

  assign nextVec = stepVec | startMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateVec <= '0;
      match    <= 1'b0;
    end else if (ctrl.loadStart) begin
      stateVec <= startMask;
      match    <= 1'b0;
    end else if (ctrl.advance) begin
      stateVec <= nextVec;
      match    <= |(nextVec & acceptMask);
    end else begin
      match    <= 1'b0;
    end
  end
endmodule

// File: rtl/nfa_matcher.sv
module nfa_matcher
  import nfa_pkg::*;
#(
  parameter int NUM_STATES  = DEF_STATES,
  parameter int NUM_CLASSES = DEF_CLASSES,
  localparam int SRC_W  = $clog2(NUM_STATES),
  localparam int ADDR_W = (2 * SRC_W > BYTE_W) ? 2 * SRC_W : BYTE_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgMode,
  input  logic                   cfgWe,
  input  logic [1:0]             cfgSel,
  input  logic [ADDR_W-1:0]      cfgAddr,
  input  logic [NUM_CLASSES-1:0] cfgData,
  input  logic                   clear,
  input  logic                   inValid,
  input  logic [BYTE_W-1:0]      inByte,
  output logic                   match,
  output logic [NUM_STATES-1:0]  stateVec
);
  nfaCtrl_t ctrl;

  nfa_ctrl u_ctrl (
    .cfgMode (cfgMode),
    .cfgWe   (cfgWe),
    .cfgSel  (cfgSel),
    .clear   (clear),
    .inValid (inValid),
    .ctrl    (ctrl)
  );

  nfa_datapath #(
    .NUM_STATES  (NUM_STATES),
    .NUM_CLASSES (NUM_CLASSES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .inByte   (inByte),
    .stateVec (stateVec),
    .match    (match)
  );
endmodule

// File: rtl/nfa_matcher_chk.sv
module nfa_matcher_chk #(
  parameter int NUM_STATES = 16,
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cfgMode,
  input logic                  cfgWe,
  input logic [1:0]            cfgSel,
  input logic [ADDR_W-1:0]     cfgAddr,
  input logic [DATA_W-1:0]     cfgData,
  input logic                  clear,
  input logic                  inValid,
  input logic [7:0]            inByte,
  input logic                  match,
  input logic [NUM_STATES-1:0] stateVec
);
  logic [NUM_STATES-1:0] startSh, acceptSh;
  logic startWrite;

  assign startWrite = cfgWe && (cfgSel == 2'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startSh  <= '0;
      acceptSh <= '0;
    end else if (cfgWe) begin
      if (cfgSel == 2'd2) startSh  <= cfgData[NUM_STATES-1:0];
      if (cfgSel == 2'd3) acceptSh <= cfgData[NUM_STATES-1:0];
    end
  end

  assert_cfg_park_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && !startWrite) |=> (stateVec == startSh && !match));

  assert_clear_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clear && !cfgMode && !startWrite) |=> (stateVec == startSh && !match));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !clear && !cfgMode) |=> ($stable(stateVec) && !match));

  assert_match_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    match |-> ((stateVec & $past(acceptSh)) != '0));

  assert_start_merged_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !clear && !cfgMode && !startWrite)
      |=> ((stateVec & startSh) == startSh));
endmodule

bind nfa_matcher nfa_matcher_chk #(
  .NUM_STATES (NUM_STATES),
  .DATA_W     (NUM_CLASSES),
  .ADDR_W     (ADDR_W)
) u_chk (.*);

// File: tb/tb_nfa_matcher.sv
module tb_nfa_matcher;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NC = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgMode = 1'b0, cfgWe = 1'b0, clear = 1'b0, inValid = 1'b0;
  logic [1:0]    cfgSel = '0;
  logic [7:0]    cfgAddr = '0, inByte = '0;
  logic [NC-1:0] cfgData = '0;
  logic          match;
  logic [NS-1:0] stateVec;

  int checks = 0, errors = 0;
  bit finished = 0;

  nfa_matcher dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench-side expectation of the configuration
  logic [NC-1:0] mCoef [NS*NS];
  logic [5:0]    mClass [256];
  logic [NS-1:0] mStart = '0, mAccept = '0, mCur = '0;

  // Scoreboard
  logic [NS-1:0] qState [$];
  logic          qMatch [$];
  string         qTag   [$];

  task automatic check(string tag, logic [NS-1:0] expS, logic expM);
    checks++;
    if (stateVec !== expS || match !== expM) begin
      errors++;
      $display("FAIL %s: stateVec=%h match=%b expected stateVec=%h match=%b",
               tag, stateVec, match, expS, expM);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (qState.size() > 0) check(qTag.pop_front(), qState.pop_front(), qMatch.pop_front());
  end

  task automatic push(string tag, logic [NS-1:0] s, logic m);
    qState.push_back(s); qMatch.push_back(m); qTag.push_back(tag);
  endtask

  task automatic cfgWrite(logic [1:0] sel, logic [7:0] addr, logic [NC-1:0] data);
    cfgMode = 1'b1; cfgWe = 1'b1; cfgSel = sel; cfgAddr = addr; cfgData = data;
    case (sel)
      2'd0: mCoef[addr] = data;
      2'd1: mClass[addr] = data[5:0];
      2'd2: mStart = data[NS-1:0];
      default: mAccept = data[NS-1:0];
    endcase
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic endCfg(string tag);
    cfgMode = 1'b1; cfgWe = 1'b0;
    mCur = mStart;
    push(tag, mStart, 1'b0);
    @(negedge clk);
    cfgMode = 1'b0;
  endtask

  task automatic sendByte(string tag, logic [7:0] b, logic v);
    logic [NS-1:0] nxt;
    logic [5:0] cls;
    inValid = v; inByte = b;
    if (v && !cfgMode) begin
      cls = mClass[b];
      nxt = mStart;
      for (int i = 0; i < NS; i++)
        for (int j = 0; j < NS; j++)
          if (mCur[j] && mCoef[i*NS+j][cls]) nxt[i] = 1'b1;
      mCur = nxt;
      push(tag, nxt, |(nxt & mAccept));
    end else if (cfgMode) begin
      mCur = mStart;
      push(tag, mStart, 1'b0);
    end else begin
      push(tag, mCur, 1'b0);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic doClear(string tag);
    clear = 1'b1;
    mCur = mStart;
    push(tag, mStart, 1'b0);
    @(negedge clk);
    clear = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < NS*NS; k++) mCoef[k] = '0;
    for (int k = 0; k < 256; k++) mClass[k] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", '0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0, 1'b0);
    // R1/R5: unconfigured automaton stays empty
    sendByte("R5 unconfigured", 8'h61, 1'b1);

    // Install: a->1, b->2, c->3
    cfgWrite(2'd1, 8'h61, 64'd1);
    cfgWrite(2'd1, 8'h62, 64'd2);
    cfgWrite(2'd1, 8'h63, 64'd3);
    cfgWrite(2'd0, 8'h10, 64'h2);               // dest1 src0 class1
    cfgWrite(2'd0, 8'h30, 64'h2);               // dest3 src0 class1
    cfgWrite(2'd0, 8'h21, 64'h4);               // dest2 src1 class2
    cfgWrite(2'd0, 8'h43, 64'h8);               // dest4 src3 class3
    cfgWrite(2'd0, 8'h54, {NC{1'b1}});          // dest5 src4 any class
    cfgWrite(2'd2, 8'h00, 64'h1);
    cfgWrite(2'd3, 8'h00, 64'h14);
    endCfg("R2 park at start");

    sendByte("R6 fan-out on a", 8'h61, 1'b1);   // 0b1011
    sendByte("R8 match on ab", 8'h62, 1'b1);    // 0b0101 match
    sendByte("R4 idle hold", 8'h00, 1'b0);
    sendByte("R5 unrelated byte", 8'h78, 1'b1); // back to start
    sendByte("R9 leading noise", 8'h7a, 1'b1);
    sendByte("R6 a again", 8'h61, 1'b1);
    sendByte("R4 idle hold 2", 8'h61, 1'b0);
    sendByte("R8 match on ac", 8'h63, 1'b1);    // bit4 match
    sendByte("R5 wildcard edge", 8'h7a, 1'b1);  // bit5, no match
    sendByte("R9 a after wildcard", 8'h61, 1'b1);
    doClear("R3 clear mid-path");
    sendByte("R3 b after clear", 8'h62, 1'b1);  // no match

    // R2: bytes during configuration are ignored
    cfgMode = 1'b1;
    sendByte("R2 byte in cfg", 8'h61, 1'b1);
    sendByte("R2 byte in cfg 2", 8'h62, 1'b1);
    cfgMode = 1'b0;
    sendByte("R2 b after cfg", 8'h62, 1'b1);

    // R7: remap 'q' to class 1, now behaves like 'a'
    cfgWrite(2'd1, 8'h71, 64'd1);
    endCfg("R7 leave cfg");
    sendByte("R7 q as class1", 8'h71, 1'b1);
    sendByte("R7 b after q", 8'h62, 1'b1);
    // R8: accept mask change removes match on state 2
    cfgWrite(2'd3, 8'h00, 64'h10);
    endCfg("R8 new accept");
    sendByte("R8 a", 8'h61, 1'b1);
    sendByte("R8 ab no match", 8'h62, 1'b1);
    sendByte("R8 tail", 8'h00, 1'b0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule